// File: doc/BRIEF.md
# Branch Trace Queue Buffer

This block records the recent control-flow history of a processor core for debug. While tracing is switched on, every taken branch, repeat-loop return or interrupt presented on the capture port stores one pair of words in a small circular queue. The source word holds a base address together with a short instruction-buffer pointer and a flag that says whether that pointer can be trusted. The destination word holds the target address. For an interrupt the source describes the last instruction executed before entry, and the destination is the first address of the handler.

Software drains the queue through one read port. It reads the source register of the oldest pair first and the destination register second. Only a full-width read of the destination register retires the pair. A third read selector returns the pre-branch instruction address. The block computes this address from the oldest source word as the base minus twice the pointer. When the queue is full a new capture replaces the oldest pair and raises a sticky overflow flag.

Top module: `branch_trace_queue`

## Requirements
- R1: After reset the queue is empty (`fill_count` = 0), `trace_on` = 0, `overflow` = 0 and `rd_data` = 0.
- R2: A write on `ctl_wr` loads `ctl_en` into `trace_on` at the next edge. A pulse on `cap_valid` stores a pair only while `trace_on` = 1. Otherwise it is ignored.
- R3: The first stored pair goes into the bottom slot. Reads always return the oldest stored pair, so pairs come out in capture order.
- R4: `rd_sel` = 0 returns the source word, laid out as bit 31 = pointer-valid flag, bits 30:28 = `cap_pid` and bits 27:0 = `cap_bsa`. `rd_sel` = 1 returns the 32-bit destination. `rd_data` is updated on the edge that samples `rd_en`.
- R5: A source read never moves the queue. A destination read with `rd_size` = 2 (word) retires the oldest pair and lowers `fill_count` by one.
- R6: A destination read with `rd_size` = 0 (byte) or 1 (half) returns the destination word but retires nothing.
- R7: `rd_sel` = 2 returns `cap_bsa - 2*cap_pid` (modulo 2^28, zero-extended) of the oldest pair. When the pointer-valid flag is 0 it returns `cap_bsa` unchanged.
- R8: The pointer-valid flag is 0 exactly when `cap_kind` = 2 (interrupt), `cap_delayed` = 1 and `cap_bsa[1:0]` = 2'b10. `cap_kind` 0 is a branch and 1 is a repeat loop.
- R9: A capture into a full queue overwrites the oldest pair and sets `overflow`. The flag holds until a `ctl_wr` with `ctl_clr_ovf` = 1, and a new overflow in that same cycle wins.
- R10: Any read of an empty queue returns 0 and leaves `fill_count` unchanged.
- R11: A capture and a retiring read in the same cycle both take effect: the oldest pair is returned and retired, and the new pair is appended. On a full queue this leaves `fill_count` unchanged and does not set `overflow`. On an empty queue the read returns 0 and the new pair is kept.
- R12: `fill_count` never exceeds the queue depth (default 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Trace enable value written by `ctl_wr` |
| ctl_clr_ovf | input | 1 | Clears the overflow flag on a control write |
| cap_valid | input | 1 | Control-flow change taken this cycle |
| cap_kind | input | 2 | 0 branch, 1 repeat loop, 2 interrupt |
| cap_delayed | input | 1 | Interrupt arrived before a delayed-branch target executed |
| cap_bsa | input | 28 | Source base address |
| cap_pid | input | 3 | Instruction-buffer pointer |
| cap_dest | input | 32 | Destination address |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | 0 source, 1 destination, 2 computed source address |
| rd_size | input | 2 | 0 byte, 1 half, 2 word |
| rd_data | output | 32 | Read result, registered |
| trace_on | output | 1 | Current trace enable |
| overflow | output | 1 | Sticky overwrite flag |
| fill_count | output | 4 | Number of stored pairs |

## Verification
A capture or a read driven in one cycle is visible one edge later. `fill_count`, `overflow` and `trace_on` are registered, and `rd_data` is registered from the head of the queue. The driver applies each stimulus on a falling edge and releases it just after the next rising edge. For every read it pushes the expected word into a scoreboard. The monitor pops and compares that word on the falling edge after the sampling rising edge, and the status outputs are checked at that same point. Expected words come from a bench-side model of the queue that follows the overwrite, empty-read and same-cycle rules.

// File: rtl/btq_pkg.sv
package btq_pkg;

    localparam int BSA_W  = 28;
    localparam int PID_W  = 3;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        EV_BRANCH = 2'd0,
        EV_REPEAT = 2'd1,
        EV_IRQ    = 2'd2
    } ev_kind_e;

    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_IA  = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic             pid_ok;
        logic [PID_W-1:0] pid;
        logic [BSA_W-1:0] bsa;
    } src_word_t;

    typedef struct packed {
        src_word_t         src;
        logic [DATA_W-1:0] dst;
    } trace_ent_t;

    // Pointer is unusable for an interrupt that lands between a delayed
    // branch and a target sitting on an odd halfword (4n+2).
    function automatic logic pid_usable(ev_kind_e kind, logic delayed,
                                        logic [BSA_W-1:0] bsa);
        return !(kind == EV_IRQ && delayed && bsa[1:0] == 2'b10);
    endfunction

    function automatic logic [BSA_W-1:0] pre_branch_addr(src_word_t s);
        logic [BSA_W-1:0] twice;
        twice = BSA_W'({s.pid, 1'b0});
        return s.pid_ok ? (s.bsa - twice) : s.bsa;
    endfunction

endpackage

// File: rtl/btq_ctrl.sv
module btq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic ctl_en,
    input  logic ctl_clr_ovf,
    input  logic ovf_evt,
    output logic trace_on,
    output logic overflow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trace_on <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (ctl_wr)
                trace_on <= ctl_en;
            if (ovf_evt)
                overflow <= 1'b1;
            else if (ctl_wr && ctl_clr_ovf)
                overflow <= 1'b0;
        end
    end
endmodule

// File: rtl/btq_ring.sv
module btq_ring
    import btq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  trace_ent_t push_ent,
    input  logic       pop,
    output trace_ent_t head_ent,
    output logic       empty,
    output logic       ovf_evt,
    output logic [CW-1:0] count
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    trace_ent_t    slot_q [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;
    logic          do_pop, overwrite, head_adv;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count_q == '0);
    assign do_pop    = pop && !empty;
    assign overwrite = push && !do_pop && (count_q == FULL);
    assign head_adv  = do_pop || overwrite;
    assign ovf_evt   = overwrite;
    assign count     = count_q;
    assign head_ent  = slot_q[head_q];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (push && tail_q == PW'(g))
                slot_q[g] <= push_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (head_adv)
                head_q <= bump(head_q);
            if (push)
                tail_q <= bump(tail_q);
            if (push && !do_pop && !overwrite)
                count_q <= count_q + 1'b1;
            else if (do_pop && !push)
                count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/btq_readport.sv
module btq_readport
    import btq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  acc_size_e         size,
    input  trace_ent_t        head_ent,
    input  logic              empty,
    output logic              pop,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_nxt;

    assign pop = rd_en && sel == SEL_DST && size == SZ_WORD && !empty;

    always_comb begin
        word_nxt = '0;
        if (!empty) begin
            case (sel)
                SEL_SRC: word_nxt = DATA_W'(head_ent.src);
                SEL_DST: word_nxt = head_ent.dst;
                SEL_IA:  word_nxt = DATA_W'(pre_branch_addr(head_ent.src));
                default: word_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= word_nxt;
    end
endmodule

// File: rtl/branch_trace_queue.sv
module branch_trace_queue
    import btq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    input  logic          ctl_clr_ovf,
    input  logic          cap_valid,
    input  logic [1:0]    cap_kind,
    input  logic          cap_delayed,
    input  logic [27:0]   cap_bsa,
    input  logic [2:0]    cap_pid,
    input  logic [31:0]   cap_dest,
    input  logic          rd_en,
    input  logic [1:0]    rd_sel,
    input  logic [1:0]    rd_size,
    output logic [31:0]   rd_data,
    output logic          trace_on,
    output logic          overflow,
    output logic [CW-1:0] fill_count
);
    trace_ent_t new_ent, head_ent;
    logic       push, pop, empty, ovf_evt;

    assign push             = cap_valid && trace_on;
    assign new_ent.src.bsa  = cap_bsa;
    assign new_ent.src.pid  = cap_pid;
    assign new_ent.src.pid_ok = pid_usable(ev_kind_e'(cap_kind), cap_delayed, cap_bsa);
    assign new_ent.dst      = cap_dest;

    btq_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .ctl_en      (ctl_en),
        .ctl_clr_ovf (ctl_clr_ovf),
        .ovf_evt     (ovf_evt),
        .trace_on    (trace_on),
        .overflow    (overflow)
    );

    btq_ring #(.DEPTH(DEPTH)) ring_i (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (new_ent),
        .pop      (pop),
        .head_ent (head_ent),
        .empty    (empty),
        .ovf_evt  (ovf_evt),
        .count    (fill_count)
    );

    btq_readport rdp_i (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .sel      (reg_sel_e'(rd_sel)),
        .size     (acc_size_e'(rd_size)),
        .head_ent (head_ent),
        .empty    (empty),
        .pop      (pop),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/btq_chk.sv
module btq_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          ctl_wr,
    input logic          ctl_clr_ovf,
    input logic          cap_valid,
    input logic          rd_en,
    input logic [1:0]    rd_sel,
    input logic [1:0]    rd_size,
    input logic [31:0]   rd_data,
    input logic          trace_on,
    input logic          overflow,
    input logic [CW-1:0] fill_count
);
    // R12
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_count <= CW'(DEPTH));

    // R2
    trace_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!trace_on && !rd_en) |=> $stable(fill_count));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !(ctl_wr && ctl_clr_ovf)) |=> overflow);

    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fill_count == '0) |=> rd_data == '0);

    // R11
    both_ways_chk: assert property (@(posedge clk) disable iff (rst)
        (trace_on && cap_valid && rd_en && rd_sel == 2'd1 && rd_size == 2'd2
         && fill_count != '0) |=> $stable(fill_count));

    // R6
    partial_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'd1 && rd_size != 2'd2 && !(trace_on && cap_valid))
        |=> $stable(fill_count));
endmodule

bind branch_trace_queue btq_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_clr_ovf (ctl_clr_ovf),
    .cap_valid   (cap_valid),
    .rd_en       (rd_en),
    .rd_sel      (rd_sel),
    .rd_size     (rd_size),
    .rd_data     (rd_data),
    .trace_on    (trace_on),
    .overflow    (overflow),
    .fill_count  (fill_count)
);

// File: tb/branch_trace_queue_tb_top.sv
`timescale 1ns/1ps
module branch_trace_queue_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 0, ctl_en = 0, ctl_clr_ovf = 0;
    logic        cap_valid = 0, cap_delayed = 0;
    logic [1:0]  cap_kind = 0;
    logic [27:0] cap_bsa = 0;
    logic [2:0]  cap_pid = 0;
    logic [31:0] cap_dest = 0;
    logic        rd_en = 0;
    logic [1:0]  rd_sel = 0, rd_size = 0;
    logic [31:0] rd_data;
    logic        trace_on, overflow;
    logic [3:0]  fill_count;

    always #10 clk = ~clk;

    branch_trace_queue #(.DEPTH(DEPTH)) dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_src[$];
    logic [31:0] m_dst[$];
    bit          m_en = 0;
    logic [31:0] sb_exp[$];
    string       sb_tag[$];
    logic        fire = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) fire <= rd_en;

    always @(negedge clk) begin
        if (fire && sb_exp.size() > 0) begin
            logic [31:0] e;
            string t;
            e = sb_exp.pop_front();
            t = sb_tag.pop_front();
            check(t, rd_data, e);
        end
    end

    function automatic logic [31:0] src_word(logic [1:0] k, logic d,
                                             logic [27:0] b, logic [2:0] p);
        logic ok;
        ok = !(k == 2'd2 && d && b[1:0] == 2'b10);
        return {ok, p, b};
    endfunction

    function automatic logic [31:0] exp_read(logic [1:0] sel);
        logic [27:0] b;
        logic [2:0]  p;
        if (m_src.size() == 0) return 32'h0;
        if (sel == 2'd0) return m_src[0];
        if (sel == 2'd1) return m_dst[0];
        b = m_src[0][27:0];
        p = m_src[0][30:28];
        return m_src[0][31] ? {4'h0, b - 28'({p, 1'b0})} : {4'h0, b};
    endfunction

    function automatic void model_push(logic [31:0] s, logic [31:0] d);
        m_src.push_back(s);
        m_dst.push_back(d);
        if (m_src.size() > DEPTH) begin
            void'(m_src.pop_front());
            void'(m_dst.pop_front());
        end
    endfunction

    task automatic ctl(logic en, logic clr);
        @(negedge clk);
        ctl_wr = 1; ctl_en = en; ctl_clr_ovf = clr;
        m_en = en;
        @(posedge clk); #1;
        ctl_wr = 0; ctl_clr_ovf = 0;
    endtask

    task automatic drive_cap(logic [1:0] k, logic d, logic [27:0] b,
                             logic [2:0] p, logic [31:0] dst);
        cap_valid = 1; cap_kind = k; cap_delayed = d;
        cap_bsa = b; cap_pid = p; cap_dest = dst;
    endtask

    task automatic capture(logic [1:0] k, logic d, logic [27:0] b,
                           logic [2:0] p, logic [31:0] dst);
        @(negedge clk);
        drive_cap(k, d, b, p, dst);
        if (m_en) model_push(src_word(k, d, b, p), dst);
        @(posedge clk); #1;
        cap_valid = 0;
    endtask

    task automatic rd(logic [1:0] sel, logic [1:0] size, string tag);
        @(negedge clk);
        rd_en = 1; rd_sel = sel; rd_size = size;
        sb_exp.push_back(exp_read(sel));
        sb_tag.push_back(tag);
        if (sel == 2'd1 && size == 2'd2 && m_src.size() > 0) begin
            void'(m_src.pop_front());
            void'(m_dst.pop_front());
        end
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic both(logic [27:0] b, logic [31:0] dst, string tag);
        @(negedge clk);
        rd_en = 1; rd_sel = 2'd1; rd_size = 2'd2;
        drive_cap(2'd0, 1'b0, b, 3'd1, dst);
        sb_exp.push_back(exp_read(2'd1));
        sb_tag.push_back(tag);
        if (m_src.size() > 0) begin
            void'(m_src.pop_front());
            void'(m_dst.pop_front());
        end
        if (m_en) model_push(src_word(2'd0, 1'b0, b, 3'd1), dst);
        @(posedge clk); #1;
        rd_en = 0; cap_valid = 0;
    endtask

    task automatic st(string tag, logic [31:0] act, logic [31:0] exp);
        @(negedge clk);
        check(tag, act, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 count", 32'(fill_count), 0);
        check("R1 overflow", 32'(overflow), 0);
        check("R1 trace_on", 32'(trace_on), 0);
        check("R1 rd_data", rd_data, 0);

        capture(2'd0, 0, 28'h0000100, 3'd1, 32'h1111_0000);
        st("R2 capture ignored while off", 32'(fill_count), 0);
        ctl(1, 0);
        st("R2 trace_on set", 32'(trace_on), 1);

        capture(2'd0, 0, 28'h0001000, 3'd2, 32'h8000_0100);
        capture(2'd1, 0, 28'h0002004, 3'd1, 32'h8000_0200);
        capture(2'd2, 1, 28'h0003002, 3'd3, 32'hA000_0600);
        capture(2'd2, 1, 28'h0004000, 3'd1, 32'hA000_0700);
        st("R3 count after four", 32'(fill_count), 4);

        rd(2'd0, 2'd2, "R4 source word A");
        rd(2'd0, 2'd2, "R5 source reread A");
        st("R5 source read keeps count", 32'(fill_count), 4);
        rd(2'd2, 2'd2, "R7 computed address A");
        rd(2'd1, 2'd0, "R6 byte dest read A");
        st("R6 byte read keeps count", 32'(fill_count), 4);
        rd(2'd1, 2'd1, "R6 half dest read A");
        rd(2'd1, 2'd2, "R4 dest word A");
        st("R5 word dest read retires", 32'(fill_count), 3);
        rd(2'd0, 2'd2, "R3 source B");
        rd(2'd1, 2'd2, "R3 dest B");
        rd(2'd0, 2'd2, "R8 source C pointer invalid");
        rd(2'd2, 2'd2, "R7 computed address C invalid pointer");
        rd(2'd1, 2'd2, "R3 dest C");
        rd(2'd0, 2'd2, "R8 source D aligned target");
        rd(2'd1, 2'd2, "R3 dest D");
        st("R3 drained", 32'(fill_count), 0);

        rd(2'd0, 2'd2, "R10 empty source read");
        rd(2'd1, 2'd2, "R10 empty dest read");
        st("R10 count stays zero", 32'(fill_count), 0);

        for (int i = 0; i < 10; i++)
            capture(2'(i % 3), 0, 28'h0010000 + 28'(i * 16), 3'(i), 32'hC000_0000 + 32'(i));
        st("R12 count capped", 32'(fill_count), DEPTH);
        st("R9 overflow set", 32'(overflow), 1);
        rd(2'd0, 2'd2, "R9 oldest overwritten");
        ctl(1, 1);
        st("R9 overflow cleared", 32'(overflow), 0);

        both(28'h0020000, 32'hD000_0001, "R11 full pop with capture");
        st("R11 count unchanged", 32'(fill_count), DEPTH);
        st("R11 no overflow", 32'(overflow), 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(2'd0, 2'd2, "R3 drain source");
            rd(2'd1, 2'd2, "R3 drain dest");
        end
        st("R3 empty after drain", 32'(fill_count), 0);

        both(28'h0030000, 32'hD000_0002, "R11 empty pop with capture");
        st("R11 empty keeps new pair", 32'(fill_count), 1);
        rd(2'd1, 2'd2, "R11 new pair readable");

        ctl(0, 0);
        capture(2'd0, 0, 28'h0040000, 3'd0, 32'hE000_0000);
        st("R2 disabled again", 32'(fill_count), 0);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule